// File: doc/BRIEF.md
# Indexed RTC Register Port Bridge

This block sits between a host processor and the register file of a real-time clock that holds 128 byte-wide registers. The host never addresses a clock register directly. It first writes a register number into an index latch. It then reads or writes that register through a single data window. The index stays in place between accesses, so software can hit one register over and over without writing the index again.

Two front ends feed the same index latch and the same register-side strobes. The first is an address-decoded pair of I/O ports. The data window sits at the even base address and the write-only index port sits at the next address up. The second is a parallel-port style path: one 8-bit data port plus three control lines. Control bit 0 sets the direction, bit 1 requests an index access and bit 2 requests a data access. This path only responds while an external enable is high, and the system must keep every other device that shares that port disabled during that time.

Every access starts on the rising edge of its strobe. Toward the register file, the bridge turns each access into exactly one single-cycle write or read pulse. Side effects such as clear-on-read in the clock therefore fire once per access, however long the host holds its strobe.

Top module: `rtc_index_bridge`

## Requirements
- R1: After a synchronous active-low reset, `reg_addr` is 0, `reg_we` and `reg_re` are low, and `host_rdata` and `pp_data_out` are 00h.
- R2: In the direct front end, an access at `BASE_ADDR` reaches the data window and an access at `BASE_ADDR`+1 reaches the index port. An access at any other address changes nothing.
- R3: A write to the data window makes `reg_we` high for one cycle, in the cycle after the rising edge of the strobe is sampled. During that cycle `reg_wdata` carries the written byte and `reg_addr` carries the current index.
- R4: A read of the data window makes `reg_re` high for exactly one cycle, however long the strobe is held. `host_rdata` shows the register byte from the second clock edge after the strobe edge onward, and holds it until the next read.
- R5: The index port is write-only. A read of it returns 00h and raises no `reg_re`.
- R6: The index latch holds 7 bits. An index write whose bit 7 is set (80h–FFh) is ignored and leaves `reg_addr` unchanged.
- R7: The index persists across data accesses, so repeated data reads and writes reach the same register.
- R8: On the parallel path, `pp_ctrl[0]`=0 means write and 1 means read, `pp_ctrl[1]`=1 selects an index access, and `pp_ctrl[2]`=1 selects a data access. Write data arrives on `pp_data_in` and read data leaves on `pp_data_out`. `pp_data_oe` is high while an enabled read strobe is held.
- R9: When `pp_ctrl[1]` and `pp_ctrl[2]` are both high, the access is an index access.
- R10: While `pp_enable` is low, the parallel path starts no access and `pp_data_oe` stays low.
- R11: When both front ends start an access on the same clock edge, the direct access is served and the parallel access is dropped.
- R12: When `host_wr` and `host_rd` are both high, the direct access is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | HADDR_W | Host I/O address |
| host_wdata | input | 8 | Host write byte |
| host_wr | input | 1 | Host write strobe (level) |
| host_rd | input | 1 | Host read strobe (level) |
| host_rdata | output | 8 | Last read result for the host |
| pp_enable | input | 1 | External gate for the parallel path |
| pp_ctrl | input | 3 | Parallel path control: [0] direction, [1] index strobe, [2] data strobe |
| pp_data_in | input | 8 | Parallel port byte from host |
| pp_data_out | output | 8 | Parallel port byte to host |
| pp_data_oe | output | 1 | Bridge drives the parallel port |
| reg_addr | output | 7 | Register number toward the clock |
| reg_wdata | output | 8 | Register write byte |
| reg_we | output | 1 | One-cycle register write pulse |
| reg_re | output | 1 | One-cycle register read pulse |
| reg_rdata | input | 8 | Register byte returned by the clock |

## Verification
The bench builds the bridge with `HADDR_W`=16 and `BASE_ADDR`=0122h. With this base, the neighbouring addresses 0121h and 0124h fall just outside the decoded pair, so near-miss decodes can be exercised. The bench holds a 128-byte register file filled with a computed pattern. That file lets the bench check index persistence, the zero returned by the write-only index port, and the rejection of index values with bit 7 set at every register. Strobes held for several cycles, simultaneous starts on both front ends, and both control bits raised together bring the edge-detection and priority rules within reach.

// File: rtl/rtc_bridge_pkg.sv
// Package: shared widths and the access request type passed from each
// front end to the bridge core.
package rtc_bridge_pkg;

    localparam int RTC_DATA_W = 8;
    localparam int RTC_IDX_W  = 7;

    // One access request, valid for a single cycle at a strobe edge.
    typedef struct packed {
        logic                  valid;
        logic                  is_index;
        logic                  is_write;
        logic [RTC_DATA_W-1:0] data;
    } rtc_acc_t;

endpackage

// File: rtl/rtc_bus_decode.sv
// Module: direct two-address front end.
// Decodes the data window at BASE_ADDR and the index port at BASE_ADDR+1.
// Turns the rising edge of a decoded strobe into a one-cycle request.
// Assumes host_addr and host_wdata stay stable while a strobe is high.
// A write wins when host_wr and host_rd are both high.
module rtc_bus_decode
    import rtc_bridge_pkg::*;
#(
    parameter int              HADDR_W   = 16,
    parameter logic [HADDR_W-1:0] BASE_ADDR = 16'h0122
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [HADDR_W-1:0]    host_addr,
    input  logic [RTC_DATA_W-1:0] host_wdata,
    input  logic                  host_wr,
    input  logic                  host_rd,
    output rtc_acc_t              req
);

    localparam logic [HADDR_W-1:0] DATA_ADDR = BASE_ADDR;
    localparam logic [HADDR_W-1:0] INDEX_ADDR = BASE_ADDR + HADDR_W'(1);

    logic hit;
    logic hit_q;

    // Decode: a strobe is active at one of the two bridge addresses.
    always_comb begin
        hit = (host_wr || host_rd) &&
              ((host_addr == DATA_ADDR) || (host_addr == INDEX_ADDR));
    end

    // Remember last cycle's decoded strobe for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit;
    end

    // Build the request on the rising edge of the decoded strobe.
    always_comb begin
        req.valid    = hit && !hit_q;
        req.is_index = (host_addr == INDEX_ADDR);
        req.is_write = host_wr;
        req.data     = host_wdata;
    end

    AST_DEC_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        req.valid |=> !req.valid); // R4

endmodule

// File: rtl/rtc_pport_front.sv
// Module: parallel-port front end.
// Control bit 0 gives direction (1 = read), bit 1 asks for an index access
// and bit 2 asks for a data access. An index access wins when both are set.
// Everything is gated by pp_enable. Assumes other devices on the port are
// disabled while pp_enable is high.
module rtc_pport_front
    import rtc_bridge_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pp_enable,
    input  logic [2:0]            pp_ctrl,
    input  logic [RTC_DATA_W-1:0] pp_data_in,
    output rtc_acc_t              req,
    output logic                  pp_data_oe
);

    logic act;
    logic act_q;

    // An enabled index or data strobe is active.
    always_comb begin
        act = pp_enable && (pp_ctrl[1] || pp_ctrl[2]);
    end

    // Remember last cycle's active strobe for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= act;
    end

    // Build the request on the rising edge; the index bit has priority.
    always_comb begin
        req.valid    = act && !act_q;
        req.is_index = pp_ctrl[1];
        req.is_write = !pp_ctrl[0];
        req.data     = pp_data_in;
    end

    // Drive the port back toward the host during an enabled read strobe.
    always_comb begin
        pp_data_oe = act && pp_ctrl[0];
    end

    AST_PP_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        req.valid |=> !req.valid); // R8

endmodule

// File: rtl/rtc_bridge_core.sv
// Module: bridge core.
// Chooses between the two front ends (direct first), keeps the 7-bit index,
// issues one-cycle write/read pulses and latches the read result.
// Assumes reg_rdata is valid in the cycle reg_re is high.
module rtc_bridge_core
    import rtc_bridge_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  rtc_acc_t              dir_req,
    input  rtc_acc_t              pp_req,
    input  logic [RTC_DATA_W-1:0] reg_rdata,
    output logic [RTC_IDX_W-1:0]  reg_addr,
    output logic [RTC_DATA_W-1:0] reg_wdata,
    output logic                  reg_we,
    output logic                  reg_re,
    output logic [RTC_DATA_W-1:0] rd_value
);

    rtc_acc_t              sel;
    logic [RTC_IDX_W-1:0]  idx_q;
    logic                  zpend_q;
    logic [RTC_DATA_W-1:0] rdata_q;

    // Fixed priority: a direct access beats a parallel one in the same cycle.
    always_comb begin
        sel = dir_req.valid ? dir_req : pp_req;
    end

    // Index latch: accept only values whose top bit is clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (sel.valid && sel.is_index && sel.is_write &&
                 !sel.data[RTC_DATA_W-1])
            idx_q <= sel.data[RTC_IDX_W-1:0];
    end

    // Register-side strobes, one cycle per accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_we    <= 1'b0;
            reg_re    <= 1'b0;
            zpend_q   <= 1'b0;
            reg_wdata <= '0;
        end else begin
            reg_we  <= sel.valid && !sel.is_index &&  sel.is_write;
            reg_re  <= sel.valid && !sel.is_index && !sel.is_write;
            zpend_q <= sel.valid &&  sel.is_index && !sel.is_write;
            if (sel.valid && !sel.is_index && sel.is_write)
                reg_wdata <= sel.data;
        end
    end

    // Read result latch: register byte on a data read, zero on an index read.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (reg_re)  rdata_q <= reg_rdata;
        else if (zpend_q) rdata_q <= '0;
    end

    assign reg_addr = idx_q;
    assign rd_value = rdata_q;

    AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re)); // R3
    AST_IDX_BIT7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.valid && sel.is_index && sel.is_write && sel.data[RTC_DATA_W-1])
        |=> $stable(idx_q)); // R6
    AST_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        zpend_q |=> (rdata_q == '0)); // R5
    AST_RE_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.valid && !sel.is_index && !sel.is_write) |=> reg_re); // R4

endmodule

// File: rtl/rtc_index_bridge.sv
// Module: top of the indexed RTC register bridge.
// Connects the direct decode and parallel-port front ends to the core.
// Both front ends reach the same index and the same register strobes.
// Assumes a single clock and a synchronous active-low reset.
module rtc_index_bridge
    import rtc_bridge_pkg::*;
#(
    parameter int                 HADDR_W   = 16,
    parameter logic [HADDR_W-1:0] BASE_ADDR = 16'h0122
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [7:0]         host_wdata,
    input  logic               host_wr,
    input  logic               host_rd,
    output logic [7:0]         host_rdata,
    input  logic               pp_enable,
    input  logic [2:0]         pp_ctrl,
    input  logic [7:0]         pp_data_in,
    output logic [7:0]         pp_data_out,
    output logic               pp_data_oe,
    output logic [6:0]         reg_addr,
    output logic [7:0]         reg_wdata,
    output logic               reg_we,
    output logic               reg_re,
    input  logic [7:0]         reg_rdata
);

    rtc_acc_t              dir_req;
    rtc_acc_t              pp_req;
    logic [RTC_DATA_W-1:0] rd_value;

    rtc_bus_decode #(
        .HADDR_W   (HADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .req        (dir_req)
    );

    rtc_pport_front u_pp (
        .clk        (clk),
        .rst_n      (rst_n),
        .pp_enable  (pp_enable),
        .pp_ctrl    (pp_ctrl),
        .pp_data_in (pp_data_in),
        .req        (pp_req),
        .pp_data_oe (pp_data_oe)
    );

    rtc_bridge_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_req   (dir_req),
        .pp_req    (pp_req),
        .reg_rdata (reg_rdata),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .rd_value  (rd_value)
    );

    assign host_rdata  = rd_value;
    assign pp_data_out = rd_value;

endmodule

// File: tb/rtc_index_bridge_test.sv
module rtc_index_bridge_test;

    localparam logic [15:0] BASE = 16'h0122;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_rdata;
    logic        pp_enable = 1'b0;
    logic [2:0]  pp_ctrl = '0;
    logic [7:0]  pp_data_in = '0;
    logic [7:0]  pp_data_out;
    logic        pp_data_oe;
    logic [6:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic        reg_we, reg_re;
    logic [7:0]  reg_rdata;

    logic [7:0] mem [128];
    int checks = 0, fails = 0, re_count = 0;

    // Reference model state
    bit       m_prev_d, m_prev_p, m_we, m_re, m_zp;
    bit [6:0] m_idx;
    bit [7:0] m_wdata, m_rdata;

    rtc_index_bridge #(.HADDR_W(16), .BASE_ADDR(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
        .pp_enable(pp_enable), .pp_ctrl(pp_ctrl), .pp_data_in(pp_data_in),
        .pp_data_out(pp_data_out), .pp_data_oe(pp_data_oe), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    always #10 clk = ~clk;

    assign reg_rdata = mem[reg_addr];

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 8'(i) ^ 8'h5A;
    end

    always @(posedge clk) begin
        if (reg_we) mem[reg_addr] <= reg_wdata;
        if (reg_re) re_count <= re_count + 1;
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        bit hit_d, act_p, e_d, e_p, isidx, wr;
        bit [7:0] d;
        if (!rst_n) begin
            m_prev_d = 0; m_prev_p = 0; m_we = 0; m_re = 0; m_zp = 0;
            m_idx = 0; m_wdata = 0; m_rdata = 0;
        end else begin
            if (m_re) m_rdata = mem[m_idx];
            else if (m_zp) m_rdata = 0;
            hit_d = (host_wr || host_rd) && (host_addr == BASE || host_addr == BASE + 1);
            e_d = hit_d && !m_prev_d; m_prev_d = hit_d;
            act_p = pp_enable && (pp_ctrl[1] || pp_ctrl[2]);
            e_p = act_p && !m_prev_p; m_prev_p = act_p;
            m_we = 0; m_re = 0; m_zp = 0;
            if (e_d || e_p) begin
                if (e_d) begin isidx = (host_addr == BASE + 1); wr = host_wr; d = host_wdata; end
                else     begin isidx = pp_ctrl[1]; wr = !pp_ctrl[0]; d = pp_data_in; end
                if (isidx && wr) begin if (!d[7]) m_idx = d[6:0]; end
                else if (isidx) m_zp = 1;
                else if (wr) begin m_we = 1; m_wdata = d; end
                else m_re = 1;
            end
        end
    end

    // Compare against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2/R7 reg_addr", reg_addr, m_idx);
            check("R3 reg_we", reg_we, m_we);
            check("R4 reg_re", reg_re, m_re);
            if (m_we) check("R3 reg_wdata", reg_wdata, m_wdata);
            check("R4 host_rdata", host_rdata, m_rdata);
            check("R8 pp_data_out", pp_data_out, m_rdata);
            check("R10 pp_data_oe", pp_data_oe,
                  pp_enable && pp_ctrl[0] && (pp_ctrl[1] || pp_ctrl[2]));
        end
    end

    task automatic dir_acc(logic [15:0] a, bit w, bit r, logic [7:0] d, int hold);
        @(negedge clk);
        host_addr = a; host_wr = w; host_rd = r; host_wdata = d;
        repeat (hold) @(negedge clk);
        host_wr = 0; host_rd = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pp_acc(bit en, logic [2:0] c, logic [7:0] d, int hold);
        @(negedge clk);
        pp_enable = en; pp_ctrl = c; pp_data_in = d;
        repeat (hold) @(negedge clk);
        pp_ctrl = 0;
        repeat (3) @(negedge clk);
        pp_enable = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int c0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset addr", reg_addr, 0);
        check("R1 reset we/re", {reg_we, reg_re}, 0);
        check("R1 reset rdata", host_rdata, 0);
        check("R1 reset pp_data_out", pp_data_out, 0);

        dir_acc(BASE + 1, 1, 0, 8'h05, 2);
        check("R2 index write", reg_addr, 5);
        dir_acc(BASE, 1, 0, 8'hAA, 2);
        check("R3 data write", mem[5], 8'hAA);

        c0 = re_count;
        dir_acc(BASE, 0, 1, 8'h00, 6);
        check("R4 one re per long strobe", re_count - c0, 1);
        check("R4 read data", host_rdata, 8'hAA);

        dir_acc(BASE, 0, 1, 8'h00, 2);
        check("R7 repeat read", host_rdata, 8'hAA);
        dir_acc(BASE, 1, 0, 8'h3C, 2);
        dir_acc(BASE, 0, 1, 8'h00, 2);
        check("R7 same register", host_rdata, 8'h3C);

        dir_acc(BASE + 1, 1, 0, 8'h85, 2);
        check("R6 bit7 index ignored", reg_addr, 5);
        dir_acc(BASE + 1, 1, 0, 8'h7F, 2);
        check("R6 top index", reg_addr, 7'h7F);

        c0 = re_count;
        dir_acc(BASE + 1, 0, 1, 8'h00, 3);
        check("R5 index read zero", host_rdata, 0);
        check("R5 index read no re", re_count - c0, 0);

        dir_acc(BASE + 2, 1, 0, 8'h11, 2);
        dir_acc(BASE - 1, 1, 0, 8'h12, 2);
        check("R2 miss addr index", reg_addr, 7'h7F);
        check("R2 miss addr mem", mem[127], 8'h7F ^ 8'h5A);

        pp_acc(1, 3'b010, 8'h10, 2);
        check("R8 pp index write", reg_addr, 7'h10);
        pp_acc(1, 3'b100, 8'h99, 2);
        check("R8 pp data write", mem[16], 8'h99);
        @(negedge clk);
        pp_enable = 1; pp_ctrl = 3'b101;
        repeat (3) @(negedge clk);
        check("R8 pp oe during read", pp_data_oe, 1);
        check("R8 pp read data", pp_data_out, 8'h99);
        pp_ctrl = 0;
        repeat (2) @(negedge clk);
        pp_enable = 0;

        pp_acc(1, 3'b110, 8'h22, 2);
        check("R9 both bits index", reg_addr, 7'h22);
        check("R9 no data write", mem[16], 8'h99);

        pp_acc(0, 3'b010, 8'h33, 2);
        check("R10 disabled ignored", reg_addr, 7'h22);
        @(negedge clk);
        pp_ctrl = 3'b101;
        @(negedge clk);
        check("R10 oe low disabled", pp_data_oe, 0);
        pp_ctrl = 0;

        @(negedge clk);
        host_addr = BASE + 1; host_wr = 1; host_wdata = 8'h01;
        pp_enable = 1; pp_ctrl = 3'b010; pp_data_in = 8'h02;
        repeat (2) @(negedge clk);
        host_wr = 0; pp_ctrl = 0;
        repeat (3) @(negedge clk);
        pp_enable = 0;
        check("R11 direct wins", reg_addr, 1);

        c0 = re_count;
        dir_acc(BASE, 1, 1, 8'h44, 2);
        check("R12 write wins", mem[1], 8'h44);
        check("R12 no read", re_count - c0, 0);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule